// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO with Ready Flags

This block carries 36-bit words from a producer clocked by one clock to a consumer clocked by an unrelated clock. Each accepted write goes into a storage array. The read side moves the oldest stored word into an output register by itself, with no request from the consumer. It then raises an output-ready flag, so the consumer sees valid data with no read latency.

The consumer takes the presented word by asserting read-enable while output-ready is high. On the write side, an input-ready flag shows whether a write will be accepted. The write and read pointers are Gray-coded and cross into the opposite domain through two-flop synchronizers. Because of this, both flags respond a fixed number of destination-clock edges after the event that moves them.

The storage depth is a parameter and must be a power of two, at least 4. The output register holds one more word, so the block holds at most depth + 1 words. Each domain has its own synchronous, active-high reset.

Top module: `xclk_ready_fifo`

## Requirements
- R1: After both resets, out_ready is 0, rd_data is 0 and in_ready is 1.
- R2: When a word is written into an empty FIFO, out_ready stays 0 after the first and second rising read-clock edges that follow the write edge. The third such edge sets out_ready to 1 and places the written word on rd_data.
- R3: Every accepted word reaches rd_data exactly once, in write order, whatever the relative pacing of writer and reader.
- R4: While out_ready is 1 and rd_en is 0, out_ready stays 1 and rd_data holds its value.
- R5: rd_en asserted while out_ready is 0 is ignored. It consumes nothing, out_ready stays 0, and a word written later is still presented.
- R6: A read-clock edge with out_ready and rd_en both 1 consumes the presented word. If another word is stored, that word appears on rd_data after the same edge and out_ready stays 1. Otherwise out_ready falls to 0.
- R7: With no reads, exactly DEPTH + 1 writes are accepted, and in_ready is then 0.
- R8: A write attempted while in_ready is 0 stores nothing. The word never appears on rd_data.
- R9: When the FIFO is full and the read side moves a word into the output register, in_ready is still 0 after the first rising write-clock edge that follows. The second such edge sets it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write request; taken when in_ready is 1 |
| wr_data | input | DATA_W | Word to store |
| in_ready | output | 1 | High when a storage location is free |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Consume the presented word; taken when out_ready is 1 |
| rd_data | output | DATA_W | Output register contents |
| out_ready | output | 1 | High when rd_data holds a word not yet consumed |

## Verification
A read pointer that moves without a matching load, or a write that is counted without being stored, shows at rd_data as a skipped, duplicated or stale word. It appears on the next presented word, so the in-order sweeps catch it within one transfer.

A synchronizer chain of the wrong length moves the out_ready rise away from the third read edge, or the in_ready recovery away from the second write edge. The bench samples those flags edge by edge after the causing event, so an off-by-one stage fails at once.

An error in the full or empty comparison shows up as the wrong accepted-write count when the FIFO is filled with no reads. It can also show up as out_ready rising with nothing stored.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

    localparam int WORD_W      = 36;
    localparam int SYNC_STAGES = 2;

    // State of the read-side output register.
    typedef enum logic {
        SLOT_STALE = 1'b0,
        SLOT_FRESH = 1'b1
    } slot_e;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/xfifo_gray_sync.sv
`timescale 1ns/1ps
module xfifo_gray_sync #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
module xfifo_store #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (wr_fire) cells[wr_addr] <= wr_data;
    end

    assign rd_q = cells[rd_addr];

endmodule

// File: rtl/xfifo_wr_side.sv
`timescale 1ns/1ps
module xfifo_wr_side
    import xfifo_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              wr_fire,
    output logic              in_ready
);

    logic [ADDR_W:0] bin_q;
    logic [ADDR_W:0] bin_nxt;
    logic [ADDR_W:0] full_mark;
    logic [31:0]     gray_wide;

    assign bin_nxt   = bin_q + 1'b1;
    assign gray_wide = bin2gray(32'(bin_nxt));

    // Full: the write pointer is one lap ahead of the synchronized read pointer.
    assign full_mark = {~rd_gray_s[ADDR_W:ADDR_W-1], rd_gray_s[ADDR_W-2:0]};
    assign in_ready  = (wr_gray != full_mark);
    assign wr_fire   = wr_en && in_ready;
    assign wr_addr   = bin_q[ADDR_W-1:0];

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            bin_q   <= '0;
            wr_gray <= '0;
        end else if (wr_fire) begin
            bin_q   <= bin_nxt;
            wr_gray <= gray_wide[ADDR_W:0];
        end
    end

endmodule

// File: rtl/xfifo_rd_side.sv
`timescale 1ns/1ps
module xfifo_rd_side
    import xfifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 10
) (
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready
);

    slot_e           slot_q;
    logic [ADDR_W:0] bin_q;
    logic [ADDR_W:0] bin_nxt;
    logic [31:0]     gray_wide;
    logic            stored_empty;
    logic            load;

    assign bin_nxt      = bin_q + 1'b1;
    assign gray_wide    = bin2gray(32'(bin_nxt));
    assign stored_empty = (rd_gray == wr_gray_s);
    assign out_ready    = (slot_q == SLOT_FRESH);
    // Reload when the register is vacant or being consumed this edge.
    assign load         = !stored_empty && (!out_ready || rd_en);
    assign rd_addr      = bin_q[ADDR_W-1:0];

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            bin_q   <= '0;
            rd_gray <= '0;
            slot_q  <= SLOT_STALE;
            rd_data <= '0;
        end else if (load) begin
            bin_q   <= bin_nxt;
            rd_gray <= gray_wide[ADDR_W:0];
            slot_q  <= SLOT_FRESH;
            rd_data <= mem_q;
        end else if (rd_en && out_ready) begin
            slot_q  <= SLOT_STALE;
        end
    end

endmodule

// File: rtl/xclk_ready_fifo.sv
`timescale 1ns/1ps
module xclk_ready_fifo
    import xfifo_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int DEPTH  = 1024
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              in_ready,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_ready
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_gray_s;
    logic [PTR_W-1:0]  rd_gray_s;
    logic              wr_fire;
    logic [DATA_W-1:0] mem_q;

    xfifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk    (wr_clk),
        .wr_rst    (wr_rst),
        .wr_en     (wr_en),
        .rd_gray_s (rd_gray_s),
        .wr_addr   (wr_addr),
        .wr_gray   (wr_gray),
        .wr_fire   (wr_fire),
        .in_ready  (in_ready)
    );

    xfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wr_clk  (wr_clk),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_q    (mem_q)
    );

    xfifo_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wr_gray),
        .q   (wr_gray_s)
    );

    xfifo_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rd_gray),
        .q   (rd_gray_s)
    );

    xfifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_clk    (rd_clk),
        .rd_rst    (rd_rst),
        .rd_en     (rd_en),
        .wr_gray_s (wr_gray_s),
        .mem_q     (mem_q),
        .rd_addr   (rd_addr),
        .rd_gray   (rd_gray),
        .rd_data   (rd_data),
        .out_ready (out_ready)
    );

endmodule

// File: rtl/xclk_ready_fifo_chk.sv
`timescale 1ns/1ps
module xclk_ready_fifo_chk #(
    parameter int DATA_W = 36,
    parameter int PTR_W  = 11
) (
    input logic              wr_clk,
    input logic              wr_rst,
    input logic              wr_en,
    input logic              in_ready,
    input logic [PTR_W-1:0]  wr_gray,
    input logic              rd_clk,
    input logic              rd_rst,
    input logic              rd_en,
    input logic              out_ready,
    input logic [DATA_W-1:0] rd_data,
    input logic [PTR_W-1:0]  rd_gray
);

    // R4: an unconsumed word stays put
    p_hold_idle_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        out_ready && !rd_en |=> out_ready && $stable(rd_data));

    // R5: with nothing presented, rd_data changes only together with a fresh load
    p_ignore_read_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !out_ready |=> $stable(rd_data) || out_ready);

    // R8: a refused write leaves the write pointer untouched
    p_drop_write_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !in_ready && wr_en |=> $stable(wr_gray));

    // R7: an accepted write advances the write pointer
    p_take_write_r7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        in_ready && wr_en |=> !$stable(wr_gray));

    // R3: pointers crossing domains change by at most one bit per edge
    p_wr_gray_step_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    p_rd_gray_step_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

bind xclk_ready_fifo xclk_ready_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst    (wr_rst),
    .wr_en     (wr_en),
    .in_ready  (in_ready),
    .wr_gray   (wr_gray),
    .rd_clk    (rd_clk),
    .rd_rst    (rd_rst),
    .rd_en     (rd_en),
    .out_ready (out_ready),
    .rd_data   (rd_data),
    .rd_gray   (rd_gray)
);

// File: tb/xclk_ready_fifo_test.sv
`timescale 1ns/1ps
module xclk_ready_fifo_test;

    localparam int DW    = 36;
    localparam int DEPTH = 8;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          wr_rst = 1'b1;
    logic          rd_rst = 1'b1;
    logic          wr_en  = 1'b0;
    logic          rd_en  = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          in_ready;
    logic          out_ready;

    int checks = 0;
    int errors = 0;

    xclk_ready_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
        .wr_clk    (wr_clk),
        .wr_rst    (wr_rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .in_ready  (in_ready),
        .rd_clk    (rd_clk),
        .rd_rst    (rd_rst),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .out_ready (out_ready)
    );

    // 200 MHz write clock; read clock offset so edges never coincide
    always #2.5 wr_clk = ~wr_clk;
    initial begin
        #0.75;
        forever #3.5 rd_clk = ~rd_clk;
    end

    function automatic logic [DW-1:0] word(input int i, input int seed);
        logic [31:0] lo;
        lo = (i * 32'h9E3779B1) ^ (seed * 32'h01010101) ^ 32'h5A5A0000;
        return {seed[3:0], lo};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        wr_en = 1'b0;
        rd_en = 1'b0;
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge rd_clk) rd_rst = 1'b0;
        repeat (3) @(posedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] d, output bit acc);
        @(negedge wr_clk);
        acc = in_ready;
        wr_en = 1'b1;
        wr_data = d;
        @(posedge wr_clk);
        #0.1 wr_en = 1'b0;
    endtask

    task automatic pop(output logic [DW-1:0] v);
        @(negedge rd_clk);
        while (!out_ready) @(negedge rd_clk);
        v = rd_data;
        rd_en = 1'b1;
        @(posedge rd_clk);
        #0.1 rd_en = 1'b0;
    endtask

    // Write one word into an empty FIFO and follow out_ready edge by edge
    task automatic latency_probe(input logic [DW-1:0] d);
        bit acc;
        push(d, acc);
        check(acc, "R2 accept", DW'(acc), DW'(1));
        @(posedge rd_clk); #0.1;
        check(out_ready == 1'b0, "R2 edge1", DW'(out_ready), DW'(0));
        @(posedge rd_clk); #0.1;
        check(out_ready == 1'b0, "R2 edge2", DW'(out_ready), DW'(0));
        @(posedge rd_clk); #0.1;
        check(out_ready == 1'b1, "R2 edge3 flag", DW'(out_ready), DW'(1));
        check(rd_data == d, "R2 edge3 data", rd_data, d);
    endtask

    task automatic stream(input int n, input int wgap, input int rgap, input int seed);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    bit acc;
                    do push(word(i, seed), acc); while (!acc);
                    repeat (wgap) @(negedge wr_clk);
                end
            end
            begin
                for (int i = 0; i < n; i++) begin
                    logic [DW-1:0] v;
                    pop(v);
                    check(v == word(i, seed), "R3 order", v, word(i, seed));
                    repeat (rgap) @(negedge rd_clk);
                end
            end
        join
    endtask

    initial begin
        #500_000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        bit acc;
        int accepted;

        // R1: reset state
        do_reset();
        @(negedge rd_clk);
        check(out_ready == 1'b0, "R1 out_ready", DW'(out_ready), DW'(0));
        check(rd_data == '0, "R1 rd_data", rd_data, '0);
        @(negedge wr_clk);
        check(in_ready == 1'b1, "R1 in_ready", DW'(in_ready), DW'(1));

        // R2: three-edge latency, several phase alignments; R4 hold while idle
        for (int k = 0; k < 6; k++) begin
            latency_probe(word(k, 7));
            repeat (3) @(posedge rd_clk);
            #0.1;
            check(out_ready && rd_data == word(k, 7), "R4 hold", rd_data, word(k, 7));
            pop(v);
            @(negedge rd_clk);
            check(out_ready == 1'b0, "R6 drained", DW'(out_ready), DW'(0));
            repeat (k + 1) @(negedge wr_clk);
        end

        // R5: reads while empty are ignored; R6 consume with nothing behind
        do_reset();
        @(negedge rd_clk) rd_en = 1'b1;
        repeat (5) begin
            @(posedge rd_clk); #0.1;
            check(out_ready == 1'b0, "R5 idle read", DW'(out_ready), DW'(0));
        end
        push(word(3, 9), acc);
        repeat (3) @(posedge rd_clk);
        #0.1;
        check(out_ready == 1'b1, "R5 flag", DW'(out_ready), DW'(1));
        check(rd_data == word(3, 9), "R5 data kept", rd_data, word(3, 9));
        @(posedge rd_clk); #0.1;
        check(out_ready == 1'b0, "R6 consumed last", DW'(out_ready), DW'(0));
        rd_en = 1'b0;

        // R7: capacity with no reads
        do_reset();
        accepted = 0;
        for (int a = 0; a < 40; a++) begin
            push(word(accepted, 4), acc);
            if (acc) accepted++;
            if (a == 20) repeat (20) @(negedge wr_clk);
        end
        repeat (20) @(negedge wr_clk);
        check(accepted == DEPTH + 1, "R7 count", DW'(accepted), DW'(DEPTH + 1));
        check(in_ready == 1'b0, "R7 full flag", DW'(in_ready), DW'(0));
        // R8: refused writes with distinct data
        for (int a = 0; a < 3; a++) begin
            push(36'hBAD00 + DW'(a), acc);
            check(!acc, "R8 refused", DW'(acc), DW'(0));
        end

        // R9: a load while full frees a slot after two write edges
        pop(v);
        check(v == word(0, 4), "R3 first", v, word(0, 4));
        @(posedge wr_clk); #1;
        check(in_ready == 1'b0, "R9 edge1", DW'(in_ready), DW'(0));
        @(posedge wr_clk); #1;
        check(in_ready == 1'b1, "R9 edge2", DW'(in_ready), DW'(1));
        push(word(DEPTH + 1, 4), acc);
        check(acc, "R9 write after recovery", DW'(acc), DW'(1));
        repeat (20) @(negedge wr_clk);

        // R6: back-to-back consumption with rd_en held
        @(negedge rd_clk) rd_en = 1'b1;
        for (int j = 0; j < DEPTH + 1; j++) begin
            check(out_ready == 1'b1, "R6 flag", DW'(out_ready), DW'(1));
            check(rd_data == word(j + 1, 4), "R6 data", rd_data, word(j + 1, 4));
            @(posedge rd_clk);
            @(negedge rd_clk);
        end
        rd_en = 1'b0;
        check(out_ready == 1'b0, "R6 empty", DW'(out_ready), DW'(0));
        repeat (10) @(negedge rd_clk);
        check(out_ready == 1'b0, "R8 nothing extra", DW'(out_ready), DW'(0));

        // R3: pacing sweep
        for (int wg = 0; wg < 4; wg++) begin
            for (int rg = 0; rg < 3; rg++) begin
                do_reset();
                stream(2 * DEPTH + 5, wg, rg * 2, wg * 3 + rg);
                @(negedge rd_clk);
                check(out_ready == 1'b0, "R3 all drained", DW'(out_ready), DW'(0));
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule